// File: doc/BRIEF.md
# Bit-Serial Column Streamer with Majority Inversion

This block takes a vector of unsigned 5-bit activations, one per lane, in a single parallel load. It then plays the vector out as bit columns, one column per clock. A column holds the same bit weight of every lane. Each column is a purely binary drive vector for the rows of a compute array, so no multi-level conversion is needed. The columns go out in order from the least significant weight to the most significant. A 3-bit weight index travels with each column.

To keep the number of rows driven high low, the block counts the ones in each column with a combinational population count. When the ones outnumber the zeros, it drives the complement of the whole column and raises an invert flag beside it, so the downstream accumulation can correct the partial sum. When the counts are equal, the column goes out unchanged.

A load is accepted only while the block is idle. The block signals completion with a done pulse that coincides with the fifth and last column. It is ready for the next vector on the cycle after that column.

Top module: `bitcol_streamer`

## Requirements
- R1: After reset, `col_valid_o` and `done_o` are 0, `ready_o` is 1, and `col_bits_o`, `col_inv_o` and `col_idx_o` are 0.
- R2: When `load_i` is sampled high while `ready_o` is 1, the block presents columns on the next five consecutive cycles with `col_valid_o` high. `col_idx_o` runs 0,1,2,3,4, so the least significant weight comes first.
- R3: Lane j occupies `act_i[5j+4:5j]`. Before any inversion, bit j of the column with index k equals bit k of lane j.
- R4: When the raw column holds more ones than zeros, `col_bits_o` is the bitwise complement of the raw column and `col_inv_o` is 1.
- R5: When the raw column holds no more ones than zeros (an equal split included), `col_bits_o` is the raw column and `col_inv_o` is 0.
- R6: `done_o` is high for exactly one cycle per vector, the cycle that carries the column with index 4.
- R7: A load request made while a stream is in progress is ignored. The stream in progress continues with the originally loaded vector, and no extra columns follow it.
- R8: On any cycle without a column, `col_valid_o` is 0 and `col_bits_o`, `col_inv_o` and `col_idx_o` are 0.
- R9: `ready_o` is 0 while columns are being issued and returns to 1 on the cycle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Request to capture `act_i` and start a stream |
| act_i | input | LANES*5 | Activation vector, lane j at bits 5j+4..5j |
| ready_o | output | 1 | Block is idle and accepts a load |
| col_valid_o | output | 1 | A real column is driven this cycle |
| col_bits_o | output | LANES | Driven column, possibly inverted |
| col_inv_o | output | 1 | Column was inverted |
| col_idx_o | output | 3 | Bit weight of the current column |
| done_o | output | 1 | Last column of the vector is driven |

## Verification
The properties assume that `load_i` matters only while `ready_o` is high. They also assume that `act_i` needs to be stable only on the cycle in which the load is accepted. Under those assumptions, the block guarantees that an issued column never carries more ones than zeros and that the index steps by one from 0 to 4. The stimulus drives loads only at a falling edge. It deliberately raises `load_i` with a different vector in the middle of a stream to confirm that busy-time requests fall outside what the block acts on. Vectors include all-zero, all-one and exact half-and-half columns, so that both sides of the majority threshold are reached.

// File: rtl/bitcol_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bit-column streamer.
// Assumes: consumers import the package before use.
package bitcol_pkg;
    // Sequencer state: idle and waiting for a load, or issuing columns.
    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_STREAM = 1'b1
    } seq_state_t;
endpackage

// File: rtl/bitcol_seq.sv
`timescale 1ns/1ps
// Column sequencer: walks the bit index from 0 to ACT_W-1 after a start.
// Assumes: start_i is only raised while busy_o is low.
module bitcol_seq
    import bitcol_pkg::*;
#(
    parameter int unsigned ACT_W = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ACT_W - 1);

    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;

    // Marks the final column of the vector.
    assign last_o = (state_q == SEQ_STREAM) && (idx_q == LAST_IDX);
    assign busy_o = (state_q == SEQ_STREAM);
    assign idx_o  = idx_q;

    // Advances the state and the column index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    idx_q <= '0;
                    if (start_i) state_q <= SEQ_STREAM;
                end
                default: begin
                    if (last_o) begin
                        state_q <= SEQ_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bitcol_gather.sv
`timescale 1ns/1ps
// Activation store and column gather: holds the loaded vector and selects
// bit idx_i of every lane.
// Assumes: lane j sits at vec bits j*ACT_W +: ACT_W; idx_i < ACT_W.
module bitcol_gather #(
    parameter int unsigned LANES = 8,
    parameter int unsigned ACT_W = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_i,
    input  logic [LANES*ACT_W-1:0] vec_i,
    input  logic [IDX_W-1:0]       idx_i,
    output logic [LANES-1:0]       raw_o
);
    logic [LANES*ACT_W-1:0] vec_q;

    // Captures the activation vector when a load is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else if (cap_i) vec_q <= vec_i;
    end

    // One selector per lane picks the current bit weight.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [ACT_W-1:0] lane_w;
        assign lane_w   = vec_q[j*ACT_W +: ACT_W];
        assign raw_o[j] = lane_w[idx_i];
    end
endmodule

// File: rtl/bitcol_majenc.sv
`timescale 1ns/1ps
// Majority encoder: counts ones in a column and complements the column
// when ones outnumber zeros; an equal split is left as is.
// Assumes: purely combinational use inside one cycle.
module bitcol_majenc #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] enc_o,
    output logic             inv_o
);
    localparam int unsigned     CNT_W = $clog2(LANES + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(LANES / 2);

    logic [CNT_W-1:0] ones;

    // Population count over all lanes.
    always_comb begin
        ones = '0;
        for (int i = 0; i < LANES; i++) ones = ones + CNT_W'(raw_i[i]);
    end

    // Strict majority of ones selects inversion.
    assign inv_o = (ones > HALF);
    assign enc_o = raw_i ^ {LANES{inv_o}};
endmodule

// File: rtl/bitcol_streamer.sv
`timescale 1ns/1ps
// Bit-serial column streamer with majority inversion (top).
// Loads LANES activations of ACT_W bits, then issues one binary column per
// cycle, least significant weight first, with an invert flag per column.
// Assumes: load_i is acted on only while ready_o is high.
module bitcol_streamer #(
    parameter int unsigned LANES = 8,
    parameter int unsigned ACT_W = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [LANES*ACT_W-1:0] act_i,
    output logic                   ready_o,
    output logic                   col_valid_o,
    output logic [LANES-1:0]       col_bits_o,
    output logic                   col_inv_o,
    output logic [IDX_W-1:0]       col_idx_o,
    output logic                   done_o
);
    logic             busy;
    logic             last;
    logic             start;
    logic [IDX_W-1:0] idx;
    logic [LANES-1:0] raw;
    logic [LANES-1:0] enc;
    logic             inv;

    // Accept a load only while idle.
    assign start = load_i && !busy;

    bitcol_seq #(.ACT_W(ACT_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .busy_o(busy), .idx_o(idx), .last_o(last)
    );

    bitcol_gather #(.LANES(LANES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_gather (
        .clk(clk), .rst_n(rst_n), .cap_i(start), .vec_i(act_i),
        .idx_i(idx), .raw_o(raw)
    );

    bitcol_majenc #(.LANES(LANES)) u_enc (
        .raw_i(raw), .enc_o(enc), .inv_o(inv)
    );

    // Output drive: columns only while streaming, zeros otherwise.
    assign ready_o     = !busy;
    assign col_valid_o = busy;
    assign col_bits_o  = busy ? enc : '0;
    assign col_inv_o   = busy && inv;
    assign col_idx_o   = busy ? idx : '0;
    assign done_o      = last;
endmodule

// File: rtl/bitcol_streamer_chk.sv
`timescale 1ns/1ps
// Checker for bitcol_streamer, attached by bind.
// Assumes: properties observe the top-level ports only.
module bitcol_streamer_chk #(
    parameter int unsigned LANES = 8,
    parameter int unsigned ACT_W = 5,
    parameter int unsigned IDX_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   load_i,
    input logic                   ready_o,
    input logic                   col_valid_o,
    input logic [LANES-1:0]       col_bits_o,
    input logic                   col_inv_o,
    input logic [IDX_W-1:0]       col_idx_o,
    input logic                   done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ACT_W - 1);

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o) |=> (col_valid_o && col_idx_o == '0)); // R2
    AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !done_o) |=> (col_valid_o && col_idx_o == $past(col_idx_o) + 1'b1)); // R2
    AST_NO_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o |-> ($countones(col_bits_o) * 2 <= LANES)); // R5
    AST_INV_MINORITY: assert property (@(posedge clk) disable iff (!rst_n)
        col_inv_o |-> ($countones(col_bits_o) * 2 < LANES)); // R4
    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (col_valid_o && col_idx_o == LAST_IDX)); // R6
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (ready_o && !col_valid_o)); // R9
    AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !done_o && load_i) |=> (col_idx_o != '0)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid_o |-> (col_bits_o == '0 && !col_inv_o && col_idx_o == '0)); // R8
endmodule

bind bitcol_streamer bitcol_streamer_chk #(.LANES(LANES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .ready_o(ready_o),
    .col_valid_o(col_valid_o), .col_bits_o(col_bits_o), .col_inv_o(col_inv_o),
    .col_idx_o(col_idx_o), .done_o(done_o)
);

// File: tb/sim_bitcol_streamer.sv
`timescale 1ns/1ps
// Bench for bitcol_streamer: table-driven streams, then directed cases.
module sim_bitcol_streamer;
    localparam int LANES = 8;
    localparam int ACT_W = 5;
    localparam int NVEC  = 6;
    localparam logic [LANES*ACT_W-1:0] VECS [NVEC] = '{
        40'h00_0000_0000,
        40'hFF_FFFF_FFFF,
        40'hAA_AAAA_AAAA,
        40'h12_3456_789A,
        40'hFF_FF00_0000,
        40'h84_2108_4210
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   load_i = 1'b0;
    logic [LANES*ACT_W-1:0] act_i = '0;
    logic                   ready_o, col_valid_o, col_inv_o, done_o;
    logic [LANES-1:0]       col_bits_o;
    logic [2:0]             col_idx_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    bitcol_streamer #(.LANES(LANES), .ACT_W(ACT_W), .IDX_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .act_i(act_i),
        .ready_o(ready_o), .col_valid_o(col_valid_o), .col_bits_o(col_bits_o),
        .col_inv_o(col_inv_o), .col_idx_o(col_idx_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Expected column from R3 (lane layout), R4 and R5 (majority rule).
    task automatic check_col(input logic [LANES*ACT_W-1:0] v, input int b);
        logic [LANES-1:0] raw, exp_bits;
        int ones;
        bit exp_inv;
        ones = 0;
        for (int j = 0; j < LANES; j++) begin
            raw[j] = v[j*ACT_W + b];
            ones += int'(raw[j]);
        end
        exp_inv  = (ones * 2 > LANES);
        exp_bits = exp_inv ? ~raw : raw;
        chk(col_valid_o == 1'b1, "R2 valid", 64'(col_valid_o), 64'd1);
        chk(col_idx_o == 3'(b), "R2 index", 64'(col_idx_o), 64'(b));
        chk(col_bits_o == exp_bits, "R3 column bits", 64'(col_bits_o), 64'(exp_bits));
        if (exp_inv)
            chk(col_inv_o == 1'b1, "R4 invert flag", 64'(col_inv_o), 64'd1);
        else
            chk(col_inv_o == 1'b0, "R5 invert flag", 64'(col_inv_o), 64'd0);
        chk(done_o == (b == ACT_W - 1), "R6 done", 64'(done_o), 64'(b == ACT_W - 1));
        chk(ready_o == 1'b0, "R9 ready while busy", 64'(ready_o), 64'd0);
    endtask

    task automatic check_idle(input string req);
        chk(col_valid_o == 1'b0, {req, " valid"}, 64'(col_valid_o), 64'd0);
        chk(col_bits_o == '0 && col_inv_o == 1'b0 && col_idx_o == '0,
            {req, " quiet outputs"}, {col_bits_o, col_inv_o, col_idx_o}, 64'd0);
        chk(done_o == 1'b0, {req, " done"}, 64'(done_o), 64'd0);
        chk(ready_o == 1'b1, {req, " ready"}, 64'(ready_o), 64'd1);
    endtask

    // Plays one vector; optionally requests a new load with w mid-stream (R7).
    task automatic play(input logic [LANES*ACT_W-1:0] v, input bit inject,
                        input logic [LANES*ACT_W-1:0] w);
        @(negedge clk);
        act_i  = v;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        for (int b = 0; b < ACT_W; b++) begin
            check_col(v, b);
            if (inject && b == 2) begin
                act_i  = w;
                load_i = 1'b1;
            end
            @(negedge clk);
            load_i = 1'b0;
        end
        check_idle("R9/R8 after stream");
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R2..R6: table of vectors
        for (int i = 0; i < NVEC; i++) play(VECS[i], 1'b0, '0);

        // R7: busy-time load with a different vector is ignored
        play(40'h0F_0F0F_0F0F, 1'b1, 40'hF0_F0F0_F0F0);
        // R7: no extra stream one cycle later either
        @(negedge clk);
        check_idle("R7 no extra columns");

        // R9: load accepted right after the idle return
        play(40'h7B_DEF7_BDEF, 1'b0, '0);

        // R8: idle with load low stays quiet for several cycles
        act_i = 40'hFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check_idle("R8 idle");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule